// File: doc/BRIEF.md
# Fully Associative Micro TLB

The micro TLB is the first, smallest translation cache on a device's request path. A lookup carries a stream context tag and a virtual page number. The lookup key is compared with every stored entry at once; no index bits are taken from the address. When the key matches, the block answers in the same cycle. The answer holds the physical page, the page attributes and the per-context configuration word that was cached alongside the translation. When no entry matches, the block forwards the lookup unchanged to the next translation level. The requester's handshake then completes when that level accepts the request.

Results that come back from the lower level arrive on a fill port and are installed in one entry. The entry is chosen in this order:
- an entry already holding the same key is overwritten;
- otherwise the lowest-numbered free entry is used;
- otherwise the victim policy picks the entry.

The victim policy is set by a static input: a rotating pointer, or a binary-tree pseudo-LRU that is refreshed by hits and by fills. Software-driven invalidation can clear the whole table, or only the entries that belong to one context, in a single cycle. The entry count must be a power of two.

Top module: `utlb_top`

## Requirements
- R1: When `req_valid` is 1 and a valid entry holds both `req_ctx` and `req_vpn`, `lk_hit` is 1 in that same cycle, `lk_ppn`, `lk_attr` and `lk_cfg` equal that entry's stored values, `req_ready` is 1 and `miss_valid` is 0.
- R2: When `req_valid` is 1 and no valid entry matches, `lk_hit` is 0, `lk_ppn`, `lk_attr` and `lk_cfg` are all zero, `miss_valid` is 1 with `miss_ctx`/`miss_vpn` equal to the request, and `req_ready` equals `miss_ready`.
- R3: A fill is accepted when `fill_valid` and `fill_ready` are both 1. Its key and data can be looked up from the next cycle on. A fill whose key is already present overwrites that entry, so at most one entry ever matches a key.
- R4: When the fill key is not present and at least one entry is invalid, the fill goes to the lowest-numbered invalid entry, and no valid entry is evicted.
- R5: With `cfg_use_plru` = 0, a fill into a full table evicts the entry named by a pointer. The pointer is 0 after reset and steps by one, modulo the entry count, only on a fill that evicts a valid entry.
- R6: With `cfg_use_plru` = 1, a fill into a full table evicts the entry chosen by a tree of N-1 bits. Node 0 is the root, and the children of node k are 2k+1 and 2k+2. A bit of 0 sends the search to the lower-numbered half. After reset all bits are 0. Each hit and each accepted fill sets the nodes on the used entry's path to point away from it; a same-cycle hit is applied before the fill. `cfg_use_plru` is held constant after reset.
- R7: `inv_all` clears every entry at the next clock edge, and all later lookups miss until new fills.
- R8: `inv_ctx_en` clears, at the next edge, exactly those entries whose context equals `inv_ctx`; entries of other contexts keep hitting.
- R9: While `inv_all` or `inv_ctx_en` is 1, `fill_ready` is 0, so no fill is installed in that cycle. A lookup in that cycle still sees the table as it was before the invalidation.
- R10: After reset every entry is invalid, so every lookup misses, and `fill_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_use_plru | input | 1 | Static victim policy: 0 rotating pointer, 1 tree pseudo-LRU |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup accepted (hit, or miss taken by lower level) |
| req_ctx | input | CTX_W | Stream context tag of the lookup |
| req_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_hit | output | 1 | Lookup hit this cycle |
| lk_ppn | output | PPN_W | Physical page of the hitting entry, zero on miss |
| lk_attr | output | ATTR_W | Attributes of the hitting entry, zero on miss |
| lk_cfg | output | CFG_W | Cached context configuration, zero on miss |
| miss_valid | output | 1 | Miss forwarded to lower level |
| miss_ready | input | 1 | Lower level accepts the forwarded miss |
| miss_ctx | output | CTX_W | Context of the forwarded miss |
| miss_vpn | output | VPN_W | Virtual page of the forwarded miss |
| fill_valid | input | 1 | Fill result from lower level present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_ctx | input | CTX_W | Context of the fill |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_attr | input | ATTR_W | Attributes of the fill |
| fill_cfg | input | CFG_W | Context configuration of the fill |
| inv_all | input | 1 | Invalidate every entry |
| inv_ctx_en | input | 1 | Invalidate entries of one context |
| inv_ctx | input | CTX_W | Context to invalidate |

## Verification
The assertions check these rules on every cycle:
- the hit, miss and handshake relations between the ports;
- that no two entries match one key;
- that a fill into a partly empty table never lands on a valid entry;
- that the rotating pointer moves exactly on evicting fills;
- that invalidation blocks the fill port and empties the table.

Whether the right entry was evicted, under either policy, only shows in later lookups. The bench therefore runs a reference table with its own tree and pointer arithmetic. It compares every lookup against that table, both in directed sequences (full-table eviction, overwrite, context and global invalidation, invalidation racing a fill) and in long random mixes under both policies.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic {
    VICT_ROTATE = 1'b0,
    VICT_TREE   = 1'b1
  } vict_pol_e;

  function automatic vict_pol_e pol_from_pin(input logic pin);
    return pin ? VICT_TREE : VICT_ROTATE;
  endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned CTX_W = 8,
  parameter int unsigned VPN_W = 20
) (
  input  logic [N-1:0]            ent_vld,
  input  logic [N-1:0][CTX_W-1:0] ent_ctx,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [CTX_W-1:0]        key_ctx,
  input  logic [VPN_W-1:0]        key_vpn,
  output logic [N-1:0]            match_vec
);

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = ent_vld[g]
                        && (ent_ctx[g] == key_ctx)
                        && (ent_vpn[g] == key_vpn);
  end

endmodule

// File: rtl/utlb_store.sv
module utlb_store #(
  parameter int unsigned N      = 8,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 24,
  parameter int unsigned ATTR_W = 4,
  parameter int unsigned CFG_W  = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_all,
  input  logic                     inv_ctx_en,
  input  logic [CTX_W-1:0]         inv_ctx,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CTX_W-1:0]         wr_ctx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PPN_W-1:0]         wr_ppn,
  input  logic [ATTR_W-1:0]        wr_attr,
  input  logic [CFG_W-1:0]         wr_cfg,
  output logic [N-1:0]             ent_vld,
  output logic [N-1:0][CTX_W-1:0]  ent_ctx,
  output logic [N-1:0][VPN_W-1:0]  ent_vpn,
  output logic [N-1:0][PPN_W-1:0]  ent_ppn,
  output logic [N-1:0][ATTR_W-1:0] ent_attr,
  output logic [N-1:0][CFG_W-1:0]  ent_cfg
);

  logic [N-1:0] vld_q;

  // valid bits: invalidation wins over a write (the write is blocked upstream anyway)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (inv_all) begin
          vld_q[i] <= 1'b0;
        end else if (inv_ctx_en && (ent_ctx[i] == inv_ctx)) begin
          vld_q[i] <= 1'b0;
        end else if (wr_en && (wr_idx == IDX_W'(i))) begin
          vld_q[i] <= 1'b1;
        end
      end
    end
  end

  // payload needs no reset: it is qualified by the valid bit
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_ctx[wr_idx]  <= wr_ctx;
      ent_vpn[wr_idx]  <= wr_vpn;
      ent_ppn[wr_idx]  <= wr_ppn;
      ent_attr[wr_idx] <= wr_attr;
      ent_cfg[wr_idx]  <= wr_cfg;
    end
  end

  assign ent_vld = vld_q;

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned NW    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_tree,
  input  logic [N-1:0]     ent_vld,
  input  logic [N-1:0]     dup_vec,
  input  logic [N-1:0]     hit_vec,
  input  logic             hit_fire,
  input  logic             fill_fire,
  output logic [IDX_W-1:0] wr_idx,
  output logic             repl_evt,
  output logic [IDX_W-1:0] rr_ptr,
  output logic [N-2:0]     tree_bits
);

  logic [IDX_W-1:0] rr_q;
  logic [N-2:0]     tree_q, tree_d;
  logic [IDX_W-1:0] hit_idx, dup_idx, free_idx, pick_idx;
  logic             has_free, has_dup;

  function automatic logic [IDX_W-1:0] oh_to_idx(input logic [N-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_free(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // walk from the root following the stored direction bits
  function automatic logic [IDX_W-1:0] tree_pick(input logic [N-2:0] t);
    logic [NW-1:0] n;
    n = '0;
    for (int l = 0; l < IDX_W; l++) begin
      n = {n[IDX_W-1:0], 1'b1} + {{IDX_W{1'b0}}, t[n[IDX_W-1:0]]};
    end
    return IDX_W'(n - NW'(N - 1));
  endfunction

  // point every node on the path of idx away from it
  function automatic logic [N-2:0] tree_touch(input logic [N-2:0] t,
                                              input logic [IDX_W-1:0] idx);
    logic [NW-1:0] n;
    logic          b;
    logic [N-2:0]  r;
    r = t;
    n = '0;
    for (int l = 0; l < IDX_W; l++) begin
      b = idx[IDX_W-1-l];
      r[n[IDX_W-1:0]] = ~b;
      n = {n[IDX_W-1:0], 1'b1} + {{IDX_W{1'b0}}, b};
    end
    return r;
  endfunction

  assign has_dup  = |dup_vec;
  assign has_free = ~&ent_vld;
  assign hit_idx  = oh_to_idx(hit_vec);
  assign dup_idx  = oh_to_idx(dup_vec);
  assign free_idx = lowest_free(ent_vld);
  assign pick_idx = use_tree ? tree_pick(tree_q) : rr_q;

  always_comb begin
    if (has_dup)       wr_idx = dup_idx;
    else if (has_free) wr_idx = free_idx;
    else               wr_idx = pick_idx;
  end

  assign repl_evt = fill_fire && !has_dup && !has_free;

  always_comb begin
    tree_d = tree_q;
    if (hit_fire)  tree_d = tree_touch(tree_d, hit_idx);
    if (fill_fire) tree_d = tree_touch(tree_d, wr_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q   <= '0;
      tree_q <= '0;
    end else begin
      tree_q <= tree_d;
      if (repl_evt) rr_q <= rr_q + IDX_W'(1);
    end
  end

  assign rr_ptr    = rr_q;
  assign tree_bits = tree_q;

endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PPN_W  = 24,
  parameter int unsigned ATTR_W = 4,
  parameter int unsigned CFG_W  = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_use_plru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [CFG_W-1:0]  lk_cfg,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [CTX_W-1:0]  miss_ctx,
  output logic [VPN_W-1:0]  miss_vpn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [CFG_W-1:0]  fill_cfg,
  input  logic              inv_all,
  input  logic              inv_ctx_en,
  input  logic [CTX_W-1:0]  inv_ctx
);

  // named internal events, also used by the bound checker
  logic [N_ENT-1:0]             valid_vec;
  logic [N_ENT-1:0]             hit_vec;
  logic [N_ENT-1:0]             dup_vec;
  logic [N_ENT-1:0][CTX_W-1:0]  e_ctx;
  logic [N_ENT-1:0][VPN_W-1:0]  e_vpn;
  logic [N_ENT-1:0][PPN_W-1:0]  e_ppn;
  logic [N_ENT-1:0][ATTR_W-1:0] e_attr;
  logic [N_ENT-1:0][CFG_W-1:0]  e_cfg;
  logic                         hit_any, hit_fire, fill_fire, repl_evt;
  logic [IDX_W-1:0]             wr_idx, rr_ptr;
  logic [N_ENT-2:0]             tree_bits;
  vict_pol_e                    pol;

  assign pol = pol_from_pin(cfg_use_plru);

  utlb_match #(.N(N_ENT), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_lk_match (
    .ent_vld(valid_vec), .ent_ctx(e_ctx), .ent_vpn(e_vpn),
    .key_ctx(req_ctx), .key_vpn(req_vpn), .match_vec(hit_vec)
  );

  utlb_match #(.N(N_ENT), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_fill_match (
    .ent_vld(valid_vec), .ent_ctx(e_ctx), .ent_vpn(e_vpn),
    .key_ctx(fill_ctx), .key_vpn(fill_vpn), .match_vec(dup_vec)
  );

  assign hit_any    = |hit_vec;
  assign lk_hit     = req_valid && hit_any;
  assign hit_fire   = lk_hit;
  assign miss_valid = req_valid && !hit_any;
  assign req_ready  = hit_any || miss_ready;
  assign miss_ctx   = req_ctx;
  assign miss_vpn   = req_vpn;

  // one-hot AND-OR read mux, zero on miss
  always_comb begin
    lk_ppn  = '0;
    lk_attr = '0;
    lk_cfg  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) begin
        lk_ppn  = lk_ppn  | e_ppn[i];
        lk_attr = lk_attr | e_attr[i];
        lk_cfg  = lk_cfg  | e_cfg[i];
      end
    end
  end

  assign fill_ready = !(inv_all || inv_ctx_en);
  assign fill_fire  = fill_valid && fill_ready;

  utlb_victim #(.N(N_ENT)) u_victim (
    .clk(clk), .rst_n(rst_n), .use_tree(pol == VICT_TREE),
    .ent_vld(valid_vec), .dup_vec(dup_vec), .hit_vec(hit_vec),
    .hit_fire(hit_fire), .fill_fire(fill_fire),
    .wr_idx(wr_idx), .repl_evt(repl_evt), .rr_ptr(rr_ptr),
    .tree_bits(tree_bits)
  );

  utlb_store #(
    .N(N_ENT), .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .ATTR_W(ATTR_W), .CFG_W(CFG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .inv_all(inv_all), .inv_ctx_en(inv_ctx_en), .inv_ctx(inv_ctx),
    .wr_en(fill_fire), .wr_idx(wr_idx),
    .wr_ctx(fill_ctx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .wr_attr(fill_attr), .wr_cfg(fill_cfg),
    .ent_vld(valid_vec), .ent_ctx(e_ctx), .ent_vpn(e_vpn),
    .ent_ppn(e_ppn), .ent_attr(e_attr), .ent_cfg(e_cfg)
  );

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_use_plru,
  input logic             req_valid,
  input logic             req_ready,
  input logic             lk_hit,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             fill_ready,
  input logic             inv_all,
  input logic             inv_ctx_en,
  input logic [N-1:0]     hit_vec,
  input logic [N-1:0]     dup_vec,
  input logic [N-1:0]     valid_vec,
  input logic             fill_fire,
  input logic             repl_evt,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rr_ptr
);

  // R1
  hit_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (req_ready && !miss_valid));

  // R2
  miss_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lk_hit) |-> (miss_valid && (req_ready == miss_ready)));

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec) && ($countones(dup_vec) <= 1));

  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_vec[$past(wr_idx)]);

  // R4
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && (dup_vec == '0) && !(&valid_vec)) |-> !valid_vec[wr_idx]);

  // R5
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_evt |=> (rr_ptr == $past(rr_ptr) + IDX_W'(1)));

  // R5
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !repl_evt |=> $stable(rr_ptr));

  // R5
  rr_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_evt && !cfg_use_plru) |-> (wr_idx == rr_ptr));

  // R6
  policy_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_use_plru));

  // R7
  inv_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

  // R9
  inv_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all || inv_ctx_en) |-> !fill_ready);

endmodule

bind utlb_top utlb_chk #(.N(N_ENT), .IDX_W(IDX_W)) u_utlb_chk (
  .clk(clk), .rst_n(rst_n), .cfg_use_plru(cfg_use_plru),
  .req_valid(req_valid), .req_ready(req_ready), .lk_hit(lk_hit),
  .miss_valid(miss_valid), .miss_ready(miss_ready), .fill_ready(fill_ready),
  .inv_all(inv_all), .inv_ctx_en(inv_ctx_en),
  .hit_vec(hit_vec), .dup_vec(dup_vec), .valid_vec(valid_vec),
  .fill_fire(fill_fire), .repl_evt(repl_evt),
  .wr_idx(wr_idx), .rr_ptr(rr_ptr)
);

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic        clk, rst_n, cfg_use_plru;
  logic        req_valid, req_ready, lk_hit, miss_valid, miss_ready;
  logic [7:0]  req_ctx, miss_ctx, fill_ctx, inv_ctx, lk_cfg, fill_cfg;
  logic [19:0] req_vpn, miss_vpn, fill_vpn;
  logic [23:0] lk_ppn, fill_ppn;
  logic [3:0]  lk_attr, fill_attr;
  logic        fill_valid, fill_ready, inv_all, inv_ctx_en;

  utlb_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_use_plru(cfg_use_plru),
    .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx), .req_vpn(req_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr), .lk_cfg(lk_cfg),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_ctx(miss_ctx), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_ctx(fill_ctx), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_attr(fill_attr), .fill_cfg(fill_cfg),
    .inv_all(inv_all), .inv_ctx_en(inv_ctx_en), .inv_ctx(inv_ctx)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference table
  bit          m_v[N];
  logic [7:0]  m_c[N];
  logic [19:0] m_vp[N];
  logic [23:0] m_p[N];
  logic [3:0]  m_a[N];
  logic [7:0]  m_g[N];
  bit   [6:0]  m_tree;
  int          m_rr;
  bit          m_plru;
  int          n_chk, n_bad;
  bit          done;

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [7:0] c, logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_c[i] == c && m_vp[i] == v) return i;
    return -1;
  endfunction

  // tree restated by bit position: level bits taken MSB first
  function automatic void m_touch(int i);
    bit [2:0] b = 3'(i);
    m_tree[0] = ~b[2];
    m_tree[1 + b[2]] = ~b[1];
    m_tree[3 + 2*b[2] + b[1]] = ~b[0];
  endfunction

  function automatic int m_pick();
    bit h, m, l;
    h = m_tree[0];
    m = m_tree[1 + h];
    l = m_tree[3 + 2*h + m];
    return 4*h + 2*m + l;
  endfunction

  function automatic void m_fill(logic [7:0] c, logic [19:0] v, logic [23:0] p,
                                 logic [3:0] a, logic [7:0] g);
    int k = m_find(c, v);
    if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
    if (k < 0) begin
      k = m_plru ? m_pick() : m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[k] = 1; m_c[k] = c; m_vp[k] = v; m_p[k] = p; m_a[k] = a; m_g[k] = g;
    m_touch(k);
  endfunction

  task automatic do_reset(bit plru);
    rst_n = 0; cfg_use_plru = plru; m_plru = plru;
    req_valid = 0; miss_ready = 0; fill_valid = 0; inv_all = 0; inv_ctx_en = 0;
    req_ctx = 0; req_vpn = 0; fill_ctx = 0; fill_vpn = 0; fill_ppn = 0;
    fill_attr = 0; fill_cfg = 0; inv_ctx = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_tree = 0; m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lookup(logic [7:0] c, logic [19:0] v, string rq);
    int e;
    bit mr = 1'($urandom_range(0, 1));
    @(negedge clk);
    req_valid = 1; req_ctx = c; req_vpn = v; miss_ready = mr;
    #1;
    e = m_find(c, v);
    check(rq, "lk_hit", 32'(lk_hit), 32'(e >= 0));
    check(rq, "lk_ppn", 32'(lk_ppn), e >= 0 ? 32'(m_p[e]) : 0);
    check(rq, "lk_attr", 32'(lk_attr), e >= 0 ? 32'(m_a[e]) : 0);
    check(rq, "lk_cfg", 32'(lk_cfg), e >= 0 ? 32'(m_g[e]) : 0);
    check(rq, "miss_valid", 32'(miss_valid), 32'(e < 0));
    check(rq, "req_ready", 32'(req_ready), 32'((e >= 0) || mr));
    if (e < 0) check(rq, "miss_key", {miss_ctx, 4'h0, miss_vpn}, {c, 4'h0, v});
    @(posedge clk);
    if (e >= 0) m_touch(e);
    #1 req_valid = 0;
  endtask

  task automatic fill(logic [7:0] c, logic [19:0] v, logic [23:0] p, string rq);
    logic [3:0] a = 4'($urandom);
    logic [7:0] g = 8'($urandom);
    @(negedge clk);
    fill_valid = 1; fill_ctx = c; fill_vpn = v; fill_ppn = p; fill_attr = a; fill_cfg = g;
    #1 check(rq, "fill_ready", 32'(fill_ready), 1);
    @(posedge clk);
    m_fill(c, v, p, a, g);
    #1 fill_valid = 0;
  endtask

  // invalidate, optionally racing a fill (R9)
  task automatic invalidate(bit all, logic [7:0] c, bit race, logic [19:0] rv);
    @(negedge clk);
    inv_all = all; inv_ctx_en = !all; inv_ctx = c;
    if (race) begin
      fill_valid = 1; fill_ctx = c; fill_vpn = rv; fill_ppn = 24'h5a5a5a;
    end
    #1 check("R9", "fill_ready", 32'(fill_ready), 0);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (all || m_c[i] == c) m_v[i] = 0;
    #1 begin inv_all = 0; inv_ctx_en = 0; fill_valid = 0; end
  endtask

  task automatic run_random(int ops, string rq);
    for (int k = 0; k < ops; k++) begin
      int op = $urandom_range(0, 99);
      logic [7:0]  c = 8'($urandom_range(0, 3));
      logic [19:0] v = 20'($urandom_range(0, 15));
      if (op < 60)      lookup(c, v, m_find(c, v) >= 0 ? "R1" : "R2");
      else if (op < 95) fill(c, v, 24'($urandom), rq);
      else if (op < 98) invalidate(0, c, 0, 0);
      else              invalidate(1, 0, 0, 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    n_chk = 0; n_bad = 0; done = 0;

    // R10 reset state, rotating policy
    do_reset(0);
    #1 check("R10", "fill_ready", 32'(fill_ready), 1);
    for (int i = 0; i < 4; i++) lookup(8'(i), 20'(i), "R10");

    // R4 fills into empty slots, R3 lookups afterwards
    for (int i = 0; i < N; i++) fill(8'd1, 20'(i), 24'(100 + i), "R4");
    for (int i = 0; i < N; i++) lookup(8'd1, 20'(i), "R3");

    // R5 full table: pointer evicts 0, then 1
    fill(8'd1, 20'd8, 24'd200, "R5");
    lookup(8'd1, 20'd0, "R5");
    lookup(8'd1, 20'd1, "R5");
    fill(8'd1, 20'd9, 24'd201, "R5");
    lookup(8'd1, 20'd1, "R5");
    lookup(8'd1, 20'd8, "R5");

    // R3 overwrite of an existing key keeps neighbours
    fill(8'd1, 20'd2, 24'habcdef, "R3");
    lookup(8'd1, 20'd2, "R3");
    lookup(8'd1, 20'd3, "R3");

    // R8 context invalidation
    fill(8'd2, 20'd100, 24'd300, "R8");
    invalidate(0, 8'd1, 0, 0);
    lookup(8'd2, 20'd100, "R8");
    lookup(8'd1, 20'd4, "R8");
    // R4 freed slots are refilled lowest first
    fill(8'd3, 20'd7, 24'd400, "R4");
    fill(8'd3, 20'd8, 24'd401, "R4");
    lookup(8'd3, 20'd7, "R4");

    // R9 lookup during invalidation sees old table
    @(negedge clk);
    req_valid = 1; req_ctx = 8'd2; req_vpn = 20'd100; inv_ctx_en = 1; inv_ctx = 8'd2;
    #1 check("R9", "lk_hit_old", 32'(lk_hit), 1);
    check("R9", "lk_ppn_old", 32'(lk_ppn), 32'd300);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (m_c[i] == 8'd2) m_v[i] = 0;
    m_touch(m_find(8'd2, 20'd100) < 0 ? 0 : 0);
    #1 begin req_valid = 0; inv_ctx_en = 0; end
    lookup(8'd2, 20'd100, "R8");

    // R7 global invalidate racing a fill (R9)
    invalidate(1, 8'd3, 1, 20'd55);
    lookup(8'd3, 20'd55, "R9");
    lookup(8'd3, 20'd7, "R7");
    lookup(8'd3, 20'd8, "R7");

    run_random(3000, "R5");

    // tree policy
    do_reset(1);
    lookup(8'd0, 20'd0, "R10");
    for (int i = 0; i < N; i++) fill(8'd5, 20'(i), 24'(500 + i), "R6");
    lookup(8'd5, 20'd0, "R6");
    lookup(8'd5, 20'd5, "R6");
    fill(8'd5, 20'd20, 24'd600, "R6");
    fill(8'd5, 20'd21, 24'd601, "R6");
    for (int i = 0; i < N; i++) lookup(8'd5, 20'(i), "R6");
    lookup(8'd5, 20'd20, "R6");
    run_random(3000, "R6");

    done = 1;
    finish_run();
  end

endmodule